// File: doc/BRIEF.md
# Partial-Tag Branch Target Buffer

This block predicts where fetch should go next when the current fetch address holds a branch. It is a set-associative table, indexed by low bits of the 64-bit program counter, that remembers the computed destinations of branches which actually went taken. To keep each entry small, only a slice of the upper address bits is kept as the tag. Two branches whose addresses differ only above that slice therefore share an entry. Such a false hit is accepted, because a wrong prediction is caught and repaired later in the pipeline.

A lookup is purely combinational from the registered fetch address. It returns a hit flag, a taken prediction and the next fetch address. When the table has no matching entry, a fixed rule decides the prediction. The rule depends on the branch kind reported by the decoder and, for conditional branches, on whether the decoded destination lies above or below the branch itself. The execute stage writes resolved branches through a single update port. Only branches that resolved taken are recorded.

Top module: `btb_partial_tag`

## Requirements
- R1: The set is selected by lookup/update address bits [IDX_LO +: IDX_W], where IDX_LO = log2(INSN_BYTES) (default bits 7:2 for 64 sets). An entry written in one set never hits for an address that maps to another set.
- R2: Hit detection compares only address bits [TAG_LO +: TAG_W] (default 31:12) with the stored tag. Addresses that differ only in bits 63:32 hit the same entry. A difference inside bits 31:12 misses.
- R3: On a hit, `lk_hit`=1 and `lk_taken`=1, and `lk_next` equals the stored target, whatever the branch kind.
- R4: An update with `up_valid`=1 and `up_taken`=0 leaves the table unchanged. Only `up_valid`=1 with `up_taken`=1 writes the tag and the full 64-bit target.
- R5: On a miss, for kind 2'b00 (conditional) with the target above the PC (unsigned compare), `lk_taken`=0 and `lk_next` = PC + INSN_BYTES.
- R6: On a miss, for kind 2'b00 with the target not above the PC, `lk_taken`=1 and `lk_next` = the decoded target.
- R7: On a miss, kinds 2'b10 and 2'b11 (indirect) give `lk_taken`=0 and `lk_next` = PC + INSN_BYTES. Kind 2'b01 (direct unconditional) gives `lk_taken`=1 and `lk_next` = target.
- R8: An update is written at the clock edge. A lookup in the same cycle still sees the old contents, and lookups from the next cycle see the new entry.
- R9: An update whose address already hits a way in its set overwrites that way in place and does not advance that set's replacement pointer.
- R10: An update that misses fills the lowest-numbered invalid way. If every way is valid, it replaces the way named by the set's round-robin pointer, which then advances by one and wraps at WAYS.
- R11: Synchronous reset clears every valid bit and every round-robin pointer, so all lookups miss afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | 64 | Registered fetch address of the branch being looked up |
| lk_kind | input | 2 | Branch kind: 00 conditional, 01 direct unconditional, 10/11 indirect |
| lk_tgt | input | 64 | Decoded destination of the branch (for the static rule) |
| lk_hit | output | 1 | Partial-tag match in the indexed set |
| lk_taken | output | 1 | Predicted taken |
| lk_next | output | 64 | Predicted next fetch address |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_taken | input | 1 | The resolved branch went taken |
| up_pc | input | 64 | Address of the resolved branch |
| up_tgt | input | 64 | Computed destination of the resolved branch |

## Verification
The hardest situation to reach from the ports is round-robin replacement in a full set. It needs several distinct partial tags aimed at one set, and an in-place rewrite placed between the fills so that a pointer that advanced wrongly would show up. The bench drives a sequence of addresses that share index bits and differ only in bits 31:12. It then reads back through lookups which of them survive each eviction. Aliasing is reached by flipping a bit above bit 31 of an address that is already stored. Same-cycle visibility is checked by doing a lookup while the update is still being presented.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam int unsigned AW = 64;

  typedef enum logic [1:0] {
    BK_COND     = 2'b00,
    BK_DIRECT   = 2'b01,
    BK_INDIRECT = 2'b10,
    BK_INDIR_AL = 2'b11
  } br_kind_e;

  // Sequential address after the branch.
  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] pc,
                                             input logic [AW-1:0] step);
    return pc + step;
  endfunction

  // A destination strictly above the branch counts as forward.
  function automatic logic is_forward(input logic [AW-1:0] pc,
                                      input logic [AW-1:0] tgt);
    return tgt > pc;
  endfunction

  // Fixed rule applied when the table has no entry.
  function automatic logic rule_taken(input logic [1:0] kind,
                                      input logic [AW-1:0] pc,
                                      input logic [AW-1:0] tgt);
    logic t;
    case (kind)
      BK_COND:   t = !is_forward(pc, tgt);
      BK_DIRECT: t = 1'b1;
      default:   t = 1'b0;
    endcase
    return t;
  endfunction

  function automatic int unsigned way_bits(input int unsigned ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction

endpackage

// File: rtl/btb_way_match.sv
module btb_way_match #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned WAY_W = btb_pkg::way_bits(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
  parameter int unsigned WAYS = 2,
  localparam int unsigned WAY_W = btb_pkg::way_bits(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAY_W-1:0] rr_ptr,
  output logic [WAY_W-1:0] victim,
  output logic             use_rr
);

  logic             free_any;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign use_rr = !free_any;
  assign victim = free_any ? free_way : rr_ptr;

endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned AW    = btb_pkg::AW,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = btb_pkg::way_bits(WAYS),
  localparam int unsigned CNT_W = $clog2(SETS * WAYS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  // lookup read port
  input  logic [IDX_W-1:0]           a_set,
  output logic [WAYS-1:0]            a_valid,
  output logic [WAYS-1:0][TAG_W-1:0] a_tags,
  output logic [WAYS-1:0][AW-1:0]    a_tgts,
  // update read port
  input  logic [IDX_W-1:0]           b_set,
  output logic [WAYS-1:0]            b_valid,
  output logic [WAYS-1:0][TAG_W-1:0] b_tags,
  output logic [WAY_W-1:0]           b_rr,
  // write port (uses b_set)
  input  logic                       we,
  input  logic [WAY_W-1:0]           we_way,
  input  logic                       we_adv,
  input  logic [TAG_W-1:0]           we_tag,
  input  logic [AW-1:0]              we_tgt,
  output logic [CNT_W-1:0]           live_cnt
);

  logic             v_q   [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [AW-1:0]    tgt_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign a_valid[w] = v_q[a_set][w];
    assign a_tags[w]  = tag_q[a_set][w];
    assign a_tgts[w]  = tgt_q[a_set][w];
    assign b_valid[w] = v_q[b_set][w];
    assign b_tags[w]  = tag_q[b_set][w];
  end
  assign b_rr = rr_q[b_set];

  function automatic logic [WAY_W-1:0] rr_next(input logic [WAY_W-1:0] p);
    return (32'(p) == WAYS - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        rr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) v_q[s][w] <= 1'b0;
      end
    end else if (we) begin
      v_q[b_set][we_way] <= 1'b1;
      if (we_adv) rr_q[b_set] <= rr_next(rr_q[b_set]);
    end
  end

  always_ff @(posedge clk) begin
    if (we && !rst) begin
      tag_q[b_set][we_way] <= we_tag;
      tgt_q[b_set][we_way] <= we_tgt;
    end
  end

  always_comb begin
    live_cnt = '0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        live_cnt = live_cnt + CNT_W'(v_q[s][w]);
  end

endmodule

// File: rtl/btb_static_pred.sv
module btb_static_pred #(
  parameter int unsigned INSN_BYTES = 4,
  localparam int unsigned AW = btb_pkg::AW
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] tgt,
  output logic          taken,
  output logic [AW-1:0] next
);

  assign taken = btb_pkg::rule_taken(kind, pc, tgt);
  assign next  = taken ? tgt : btb_pkg::seq_addr(pc, AW'(INSN_BYTES));

endmodule

// File: rtl/btb_partial_tag.sv
module btb_partial_tag #(
  parameter int unsigned SETS       = 64,
  parameter int unsigned WAYS       = 2,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned TAG_LO     = 12,
  parameter int unsigned TAG_W      = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] lk_pc,
  input  logic [1:0]  lk_kind,
  input  logic [63:0] lk_tgt,
  output logic        lk_hit,
  output logic        lk_taken,
  output logic [63:0] lk_next,
  input  logic        up_valid,
  input  logic        up_taken,
  input  logic [63:0] up_pc,
  input  logic [63:0] up_tgt
);

  localparam int unsigned AW     = btb_pkg::AW;
  localparam int unsigned IDX_LO = $clog2(INSN_BYTES);
  localparam int unsigned IDX_W  = $clog2(SETS);
  localparam int unsigned WAY_W  = btb_pkg::way_bits(WAYS);
  localparam int unsigned CNT_W  = $clog2(SETS * WAYS + 1);

  // address slicing
  logic [IDX_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  assign lk_set = lk_pc[IDX_LO +: IDX_W];
  assign up_set = up_pc[IDX_LO +: IDX_W];
  assign lk_tag = lk_pc[TAG_LO +: TAG_W];
  assign up_tag = up_pc[TAG_LO +: TAG_W];

  // storage
  logic [WAYS-1:0]            a_valid, b_valid;
  logic [WAYS-1:0][TAG_W-1:0] a_tags, b_tags;
  logic [WAYS-1:0][AW-1:0]    a_tgts;
  logic [WAY_W-1:0]           up_rr;
  logic                       wr_en, wr_adv;
  logic [WAY_W-1:0]           wr_way;
  logic [CNT_W-1:0]           live_cnt;

  btb_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .a_set(lk_set), .a_valid(a_valid), .a_tags(a_tags), .a_tgts(a_tgts),
    .b_set(up_set), .b_valid(b_valid), .b_tags(b_tags), .b_rr(up_rr),
    .we(wr_en), .we_way(wr_way), .we_adv(wr_adv),
    .we_tag(up_tag), .we_tgt(up_tgt), .live_cnt(live_cnt)
  );

  // lookup side
  logic [WAYS-1:0]  lk_way_hit;
  logic [WAY_W-1:0] lk_way;
  logic             tbl_hit;

  btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid(a_valid), .tags(a_tags), .key(lk_tag),
    .hit_vec(lk_way_hit), .hit(tbl_hit), .hit_way(lk_way)
  );

  logic          st_taken;
  logic [AW-1:0] st_next;

  btb_static_pred #(.INSN_BYTES(INSN_BYTES)) u_static (
    .kind(lk_kind), .pc(lk_pc), .tgt(lk_tgt),
    .taken(st_taken), .next(st_next)
  );

  assign lk_hit   = tbl_hit;
  assign lk_taken = tbl_hit | st_taken;
  assign lk_next  = tbl_hit ? a_tgts[lk_way] : st_next;

  // update side
  logic [WAYS-1:0]  up_way_hit;
  logic [WAY_W-1:0] up_way;
  logic             up_hit;
  logic [WAY_W-1:0] vic_way;
  logic             vic_rr;
  logic             up_fire;

  btb_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .valid(b_valid), .tags(b_tags), .key(up_tag),
    .hit_vec(up_way_hit), .hit(up_hit), .hit_way(up_way)
  );

  btb_victim #(.WAYS(WAYS)) u_victim (
    .valid(b_valid), .rr_ptr(up_rr), .victim(vic_way), .use_rr(vic_rr)
  );

  assign up_fire = up_valid & up_taken;
  assign wr_en   = up_fire;
  assign wr_way  = up_hit ? up_way : vic_way;
  assign wr_adv  = up_fire & ~up_hit & vic_rr;

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int unsigned WAYS       = 2,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned WAY_W      = 1,
  parameter int unsigned CNT_W      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [63:0]      lk_pc,
  input logic [1:0]       lk_kind,
  input logic [63:0]      lk_tgt,
  input logic             lk_hit,
  input logic             lk_taken,
  input logic [63:0]      lk_next,
  input logic             up_valid,
  input logic             up_taken,
  input logic [63:0]      up_pc,
  input logic [63:0]      up_tgt,
  input logic [WAYS-1:0]  lk_way_hit,
  input logic [WAYS-1:0]  up_way_hit,
  input logic [WAY_W-1:0] up_rr,
  input logic [CNT_W-1:0] live_cnt
);

  p_hit_taken_r3: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_taken);

  p_no_dup_way_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_way_hit) && $onehot0(up_way_hit));

  p_quiet_update_r4: assert property (@(posedge clk) disable iff (rst)
    !(up_valid && up_taken) |=> live_cnt == $past(live_cnt));

  p_fwd_cond_r5: assert property (@(posedge clk) disable iff (rst)
    (!lk_hit && lk_kind == 2'b00 && lk_tgt > lk_pc)
      |-> (!lk_taken && lk_next == lk_pc + 64'(INSN_BYTES)));

  p_bwd_cond_r6: assert property (@(posedge clk) disable iff (rst)
    (!lk_hit && lk_kind == 2'b00 && lk_tgt <= lk_pc)
      |-> (lk_taken && lk_next == lk_tgt));

  p_indirect_r7: assert property (@(posedge clk) disable iff (rst)
    (!lk_hit && lk_kind[1]) |-> (!lk_taken && lk_next == lk_pc + 64'(INSN_BYTES)));

  p_direct_r7: assert property (@(posedge clk) disable iff (rst)
    (!lk_hit && lk_kind == 2'b01) |-> (lk_taken && lk_next == lk_tgt));

  p_visible_next_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(up_valid && up_taken) && lk_pc == $past(up_pc))
      |-> (lk_hit && lk_next == $past(up_tgt)));

  p_rr_range_r10: assert property (@(posedge clk) disable iff (rst)
    32'(up_rr) < WAYS);

  p_reset_empty_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> live_cnt == '0);

endmodule

bind btb_partial_tag btb_checker #(
  .WAYS(WAYS), .INSN_BYTES(INSN_BYTES), .WAY_W(WAY_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_kind(lk_kind), .lk_tgt(lk_tgt),
  .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next(lk_next),
  .up_valid(up_valid), .up_taken(up_taken), .up_pc(up_pc), .up_tgt(up_tgt),
  .lk_way_hit(lk_way_hit), .up_way_hit(up_way_hit), .up_rr(up_rr),
  .live_cnt(live_cnt)
);

// File: tb/btb_partial_tag_tb.sv
module btb_partial_tag_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] lk_pc = '0, lk_tgt = '0, up_pc = '0, up_tgt = '0;
  logic [1:0]  lk_kind = 2'b00;
  logic        up_valid = 1'b0, up_taken = 1'b0;
  logic        lk_hit, lk_taken;
  logic [63:0] lk_next;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  btb_partial_tag u_dut (
    .clk(clk), .rst(rst),
    .lk_pc(lk_pc), .lk_kind(lk_kind), .lk_tgt(lk_tgt),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next(lk_next),
    .up_valid(up_valid), .up_taken(up_taken), .up_pc(up_pc), .up_tgt(up_tgt)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present a lookup; sample after the combinational path settles.
  task automatic look(input logic [63:0] pc, input logic [1:0] kind,
                      input logic [63:0] tgt);
    lk_pc = pc; lk_kind = kind; lk_tgt = tgt;
    #1;
  endtask

  task automatic expect_hit(input logic [63:0] pc, input logic [63:0] tgt,
                            input string req);
    look(pc, 2'b00, pc + 64'h100);
    chk(lk_hit === 1'b1, req, 64'(lk_hit), 64'd1);
    chk(lk_next === tgt && lk_taken === 1'b1, req, lk_next, tgt);
  endtask

  task automatic expect_miss(input logic [63:0] pc, input string req);
    look(pc, 2'b00, pc + 64'h100);
    chk(lk_hit === 1'b0, req, 64'(lk_hit), 64'd0);
  endtask

  task automatic update(input logic [63:0] pc, input logic [63:0] tgt,
                        input bit taken);
    up_valid = 1'b1; up_taken = taken; up_pc = pc; up_tgt = tgt;
    @(negedge clk);
    up_valid = 1'b0; up_taken = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_miss(64'h0000_0000_0000_1000, "R11");
    expect_miss(64'h0000_0000_0001_0040, "R11");
    expect_miss(64'hFFFF_FFFF_FFFF_FFFC, "R11");
  endtask

  task automatic t_static();
    logic [63:0] pc = 64'h0000_0000_0000_1000;
    look(pc, 2'b00, 64'h1100);
    chk(!lk_taken && lk_next === pc + 64'd4, "R5", lk_next, pc + 64'd4);
    look(pc, 2'b00, 64'h0F00);
    chk(lk_taken && lk_next === 64'h0F00, "R6", lk_next, 64'h0F00);
    look(pc, 2'b00, pc);
    chk(lk_taken && lk_next === pc, "R6", lk_next, pc);
    look(pc, 2'b10, 64'h0F00);
    chk(!lk_taken && lk_next === pc + 64'd4, "R7", lk_next, pc + 64'd4);
    look(pc, 2'b11, 64'h0F00);
    chk(!lk_taken && lk_next === pc + 64'd4, "R7", lk_next, pc + 64'd4);
    look(pc, 2'b01, 64'h2000);
    chk(lk_taken && lk_next === 64'h2000, "R7", lk_next, 64'h2000);
  endtask

  task automatic t_hit_and_ignore();
    logic [63:0] p = 64'h0000_0000_0000_5010;
    up_valid = 1'b1; up_taken = 1'b1; up_pc = p; up_tgt = 64'h8000;
    look(p, 2'b00, p + 64'h100);
    chk(lk_hit === 1'b0, "R8 same cycle", 64'(lk_hit), 64'd0);
    @(negedge clk);
    up_valid = 1'b0; up_taken = 1'b0;
    expect_hit(p, 64'h8000, "R8 next cycle");
    look(p, 2'b10, 64'h0);
    chk(lk_taken && lk_next === 64'h8000, "R3", lk_next, 64'h8000);
    update(64'h0000_0000_0000_6020, 64'h9000, 1'b0);
    expect_miss(64'h0000_0000_0000_6020, "R4");
    expect_hit(p, 64'h8000, "R4");
  endtask

  task automatic t_alias();
    logic [63:0] p = 64'h0000_0000_0000_5010;
    expect_hit(p ^ (64'd1 << 40), 64'h8000, "R2 upper bits ignored");
    expect_hit(p ^ (64'd1 << 63), 64'h8000, "R2 upper bits ignored");
    expect_miss(p ^ (64'd1 << 20), "R2 tag bit");
    expect_miss(p ^ (64'd1 << 31), "R2 tag bit");
    expect_miss(p + 64'd4, "R1 other set");
  endtask

  task automatic t_replace();
    logic [63:0] a = 64'h0000_0000_0001_0040;
    logic [63:0] b = 64'h0000_0000_0002_0040;
    logic [63:0] c = 64'h0000_0000_0003_0040;
    logic [63:0] d = 64'h0000_0000_0004_0040;
    do_reset();
    update(a, 64'hA000, 1'b1);
    update(b, 64'hB000, 1'b1);
    expect_hit(a, 64'hA000, "R10 free way");
    expect_hit(b, 64'hB000, "R10 free way");
    update(a, 64'hA111, 1'b1);
    expect_hit(a, 64'hA111, "R9 in place");
    expect_hit(b, 64'hB000, "R9 in place");
    update(c, 64'hC000, 1'b1);
    expect_miss(a, "R10 evict way0");
    expect_hit(b, 64'hB000, "R9 pointer unchanged");
    expect_hit(c, 64'hC000, "R10");
    update(d, 64'hD000, 1'b1);
    expect_miss(b, "R10 evict way1");
    expect_hit(c, 64'hC000, "R10");
    expect_hit(d, 64'hD000, "R10");
    do_reset();
    expect_miss(c, "R11 after fill");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_static();
    t_hit_and_ignore();
    t_alias();
    t_replace();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule